// File: doc/BRIEF.md
# Dual-Mode Host Parallel Bus Capture

This block is the host-facing front end of a display-link serializer. It samples a 16-bit asynchronous processor bus with a fast internal clock. It turns each finished bus write into a single transaction word, which it presents on a valid/ready output. A static style input selects how the strobes are read. In the 8080 style, separate active-low read and write strobes are used. In the 6800 style, an active-high enable and a read/write line are used. Two active-low chip selects pick a primary or a secondary display, and the transaction records which of them was low.

A read takes two bus accesses. The first read access sends a read-request transaction with the read flag set and a zero data field. The far end returns a word through `rdat_valid`/`rdat`, which raises `irq`. The second read access drives the held word onto the bus, and its completion lowers `irq`. A low `awake` input holds the block in a power-down state. In that state nothing is issued and the interrupt is cleared.

The controller has four states:

| State | Meaning |
|-------|---------|
| `ST_OFF` | Powered down. |
| `ST_IDLE` | Ready for any access. |
| `ST_REQ_WAIT` | A read request has been sent and the block is waiting for the returned word. |
| `ST_DATA_RDY` | The returned word is held and `irq` is high. |

The transitions are:

- **OFF→IDLE**: taken when `awake` is seen high.
- **IDLE→REQ_WAIT**: taken on a completed read access.
- **REQ_WAIT→DATA_RDY**: taken on `rdat_valid`.
- **DATA_RDY→IDLE**: taken on a completed read access.
- **any→OFF**: taken when `awake` is seen low.

In REQ_WAIT, further read accesses are ignored. Writes are accepted in IDLE, REQ_WAIT and DATA_RDY.

Top module: `hostbus_capture`

## Requirements
- R1: With `mode_i80`=1, a write is an access with a chip select low and `strobe_b` (write, active low) low; it is captured when `strobe_b` rises.
- R2: In 8080 style, if the chip select returns high before the write strobe, the write is captured at the chip-select rising edge with the same data.
- R3: With `mode_i80`=0, `strobe_a` is the active-high enable and `strobe_b` is read/write (1 = read, 0 = write); the access is captured when the enable falls.
- R4: In 6800 style, with the enable held high, the access is captured when the chip select rises.
- R5: A strobe with both chip selects high is ignored. `txn_sel` bit 0 is set when the primary select (`cs_n[0]`) was low, and bit 1 when the secondary select (`cs_n[1]`) was low.
- R6: `txn_ad` carries the `ad_flag` level of the access (1 = data, 0 = command/address). `txn_data` carries the bus data of a write.
- R7: A read access in ST_IDLE issues one transaction with `txn_rd`=1 and `txn_data`=0. `irq` stays low.
- R8: `rdat_valid` in ST_REQ_WAIT stores `rdat` and raises `irq`. Completion of the next read access lowers `irq` and issues no transaction.
- R9: `bus_doe` is high only while `irq` is high, a chip select is low and the read strobe is active (8080: `strobe_a` low; 6800: `strobe_a` and `strobe_b` high). While high, `bus_dout` carries the stored word.
- R10: While `awake` is low, the block enters ST_OFF. `irq` goes low, the pending transaction is dropped, and no new transaction is issued.
- R11: An offered transaction stays valid and unchanged until `txn_ready`. A new transaction completing while one is unaccepted is dropped and sets the sticky `txn_ovf` flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i80 | input | 1 | Static bus style: 1 = 8080, 0 = 6800 |
| awake | input | 1 | Low = power-down |
| cs_n | input | NCS | Active-low chip selects, bit 0 primary |
| strobe_a | input | 1 | 8080 read strobe (low) / 6800 enable (high) |
| strobe_b | input | 1 | 8080 write strobe (low) / 6800 read-high write-low |
| ad_flag | input | 1 | 1 = data, 0 = command |
| bus_din | input | DW | Bus data in |
| bus_dout | output | DW | Read data out |
| bus_doe | output | 1 | Bus output enable |
| rdat_valid | input | 1 | Returned read word valid |
| rdat | input | DW | Returned read word |
| txn_valid | output | 1 | Transaction offered |
| txn_ready | input | 1 | Transaction taken |
| txn_data | output | DW | Write data, 0 for a read request |
| txn_ad | output | 1 | Address/data flag of the access |
| txn_rd | output | 1 | 1 = read request |
| txn_sel | output | NCS | Active chip selects of the access |
| txn_ovf | output | 1 | Sticky overflow flag |
| irq | output | 1 | Returned data ready |

## Verification
A wrong controller state is visible on `irq` in the first clock after the faulty transition. It also shows as a missing or extra read-request transaction about three clocks after the next strobe release. A wrong synchronizer or edge decode produces a transaction with the wrong data, flag or select, or one on the wrong edge. These appear three clocks after the input edge. A faulty holding register shows at once as a `txn_valid` that drops without `txn_ready`, or as a missing `txn_ovf`. A reference model is therefore compared with every output on every clock.

// File: rtl/hbc_pkg.sv
package hbc_pkg;
    typedef enum logic [1:0] {
        ST_OFF,
        ST_IDLE,
        ST_REQ_WAIT,
        ST_DATA_RDY
    } hbc_state_e;
endpackage

// File: rtl/hbc_sync.sv
// Multi-stage synchronizer for a bundle of asynchronous inputs.
module hbc_sync #(
    parameter int          W       = 1,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= {STAGES{RST_VAL}};
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/hbc_decode.sv
// Turns synchronized strobes into access-complete pulses and captured fields.
module hbc_decode #(
    parameter int DW  = 16,
    parameter int NCS = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           mode_i80,
    input  logic [NCS-1:0] cs_n_s,
    input  logic           sa_s,
    input  logic           sb_s,
    input  logic           ad_s,
    input  logic [DW-1:0]  din_s,
    output logic           wr_done,
    output logic           rd_done,
    output logic [DW-1:0]  cap_data,
    output logic           cap_ad,
    output logic [NCS-1:0] cap_sel
);
    logic cs_any, wr_act, rd_act, wr_q, rd_q;
    logic [NCS-1:0] cs_q;

    always_comb begin
        cs_any = |(~cs_n_s);
        if (mode_i80) begin
            wr_act = cs_any & ~sb_s;
            rd_act = cs_any & ~sa_s;
        end else begin
            wr_act = cs_any & sa_s & ~sb_s;
            rd_act = cs_any & sa_s & sb_s;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q     <= 1'b0;
            rd_q     <= 1'b0;
            cs_q     <= '1;
            cap_data <= '0;
            cap_ad   <= 1'b0;
        end else begin
            wr_q     <= wr_act;
            rd_q     <= rd_act;
            cs_q     <= cs_n_s;
            cap_data <= din_s;
            cap_ad   <= ad_s;
        end
    end

    // An access ends on whichever of its qualifying inputs drops first.
    assign wr_done = wr_q & ~wr_act;
    assign rd_done = rd_q & ~rd_act;
    assign cap_sel = ~cs_q;
endmodule

// File: rtl/hostbus_capture.sv
module hostbus_capture #(
    parameter int DW          = 16,
    parameter int NCS         = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           mode_i80,
    input  logic           awake,
    input  logic [NCS-1:0] cs_n,
    input  logic           strobe_a,
    input  logic           strobe_b,
    input  logic           ad_flag,
    input  logic [DW-1:0]  bus_din,
    output logic [DW-1:0]  bus_dout,
    output logic           bus_doe,
    input  logic           rdat_valid,
    input  logic [DW-1:0]  rdat,
    output logic           txn_valid,
    input  logic           txn_ready,
    output logic [DW-1:0]  txn_data,
    output logic           txn_ad,
    output logic           txn_rd,
    output logic [NCS-1:0] txn_sel,
    output logic           txn_ovf,
    output logic           irq
);
    import hbc_pkg::*;

    localparam int SW = DW + NCS + 4;
    localparam logic [SW-1:0] SYNC_RST = {1'b0, {NCS{1'b1}}, 3'b000, {DW{1'b0}}};

    logic [SW-1:0]  raw_bus, syn_bus;
    logic           awake_s, sa_s, sb_s, ad_s;
    logic [NCS-1:0] cs_s;
    logic [DW-1:0]  din_s;
    logic           wr_done, rd_done, cap_ad, issue;
    logic [DW-1:0]  cap_data, rd_hold;
    logic [NCS-1:0] cap_sel;
    logic           raw_read;
    hbc_state_e     state, nxt;

    assign raw_bus = {awake, cs_n, strobe_a, strobe_b, ad_flag, bus_din};

    hbc_sync #(.W(SW), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(raw_bus), .q(syn_bus)
    );

    assign din_s   = syn_bus[DW-1:0];
    assign ad_s    = syn_bus[DW];
    assign sb_s    = syn_bus[DW+1];
    assign sa_s    = syn_bus[DW+2];
    assign cs_s    = syn_bus[DW+3 +: NCS];
    assign awake_s = syn_bus[SW-1];

    hbc_decode #(.DW(DW), .NCS(NCS)) u_dec (
        .clk(clk), .rst_n(rst_n), .mode_i80(mode_i80), .cs_n_s(cs_s),
        .sa_s(sa_s), .sb_s(sb_s), .ad_s(ad_s), .din_s(din_s),
        .wr_done(wr_done), .rd_done(rd_done), .cap_data(cap_data),
        .cap_ad(cap_ad), .cap_sel(cap_sel)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= nxt;
    end

    // Next-state logic
    always_comb begin
        nxt = state;
        if (!awake_s) begin
            nxt = ST_OFF;
        end else begin
            unique case (state)
                ST_OFF:      nxt = ST_IDLE;
                ST_IDLE:     if (rd_done)    nxt = ST_REQ_WAIT;
                ST_REQ_WAIT: if (rdat_valid) nxt = ST_DATA_RDY;
                ST_DATA_RDY: if (rd_done)    nxt = ST_IDLE;
            endcase
        end
    end

    assign issue = awake_s && (state != ST_OFF) &&
                   (wr_done || (rd_done && state == ST_IDLE));

    // One-deep transaction holding register with overflow flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            txn_valid <= 1'b0;
            txn_data  <= '0;
            txn_ad    <= 1'b0;
            txn_rd    <= 1'b0;
            txn_sel   <= '0;
            txn_ovf   <= 1'b0;
        end else if (state == ST_OFF) begin
            txn_valid <= 1'b0;
        end else begin
            if (issue && (!txn_valid || txn_ready)) begin
                txn_valid <= 1'b1;
                txn_rd    <= ~wr_done;
                txn_data  <= wr_done ? cap_data : '0;
                txn_ad    <= cap_ad;
                txn_sel   <= cap_sel;
            end else if (txn_valid && txn_ready) begin
                txn_valid <= 1'b0;
            end
            if (issue && txn_valid && !txn_ready) txn_ovf <= 1'b1;
        end
    end

    // Returned read word
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                   rd_hold <= '0;
        else if (state == ST_REQ_WAIT && rdat_valid) rd_hold <= rdat;
    end

    // Outputs
    always_comb begin
        raw_read = mode_i80 ? ~strobe_a : (strobe_a & strobe_b);
        irq      = (state == ST_DATA_RDY);
        bus_dout = rd_hold;
        bus_doe  = irq && (|(~cs_n)) && raw_read;
    end

    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        txn_valid && !txn_ready && state != ST_OFF |=> txn_valid && $stable(txn_data));

    p_no_overflow_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        txn_ovf |=> txn_ovf);

    p_off_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_OFF |=> !txn_valid);

    p_req_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        txn_valid && txn_rd |-> txn_data == '0);

    p_irq_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_REQ_WAIT && rdat_valid && awake_s |=> irq && bus_dout == $past(rdat));
endmodule

// File: tb/sim_hostbus_capture.sv
module sim_hostbus_capture;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode = 1'b1, awake = 1'b0;
    logic [1:0]  csn = 2'b11;
    logic        sa = 1'b1, sb = 1'b1, ad = 1'b0;
    logic [15:0] din = '0, rdat = '0;
    logic        rdv = 1'b0, ready = 1'b1;
    logic [15:0] dout, t_data;
    logic        doe, t_valid, t_ad, t_rd, t_ovf, irq;
    logic [1:0]  t_sel;

    int checks = 0, failures = 0, cyc = 0, n_acc = 0;
    bit done = 0;
    logic [15:0] l_data; logic l_ad, l_rd; logic [1:0] l_sel;

    always #5 clk = ~clk;

    hostbus_capture u0 (
        .clk(clk), .rst_n(rst_n), .mode_i80(mode), .awake(awake), .cs_n(csn),
        .strobe_a(sa), .strobe_b(sb), .ad_flag(ad), .bus_din(din),
        .bus_dout(dout), .bus_doe(doe), .rdat_valid(rdv), .rdat(rdat),
        .txn_valid(t_valid), .txn_ready(ready), .txn_data(t_data), .txn_ad(t_ad),
        .txn_rd(t_rd), .txn_sel(t_sel), .txn_ovf(t_ovf), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    // ---------------- reference model ----------------
    logic       h_aw [3]; logic [1:0] h_cs [3]; logic h_a [3]; logic h_b [3];
    logic       h_ad [3]; logic [15:0] h_d [3];
    int         m_state;
    logic       m_valid, m_ad, m_rd, m_ovf;
    logic [15:0] m_data, m_hold;
    logic [1:0] m_sel;

    function automatic logic [1:0] acts(logic md, logic [1:0] c_n, logic a, logic b);
        logic c;
        c = ~&c_n;
        if (md) return {c & ~b, c & ~a};
        return {c & a & ~b, c & a & b};
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < 3; i++) begin
                h_aw[i] = 0; h_cs[i] = 2'b11; h_a[i] = 0; h_b[i] = 0; h_ad[i] = 0; h_d[i] = 0;
            end
            m_state = 0; m_valid = 0; m_ad = 0; m_rd = 0; m_ovf = 0;
            m_data = 0; m_hold = 0; m_sel = 0;
        end else begin
            logic [1:0] cur, prv;
            logic wd, rdn, aw, iss, old_v;
            aw  = h_aw[1];
            cur = acts(mode, h_cs[1], h_a[1], h_b[1]);
            prv = acts(mode, h_cs[2], h_a[2], h_b[2]);
            wd  = prv[1] & ~cur[1];
            rdn = prv[0] & ~cur[0];
            iss = aw && m_state != 0 && (wd || (rdn && m_state == 1));
            old_v = m_valid;
            if (m_state == 0) m_valid = 0;
            else begin
                if (iss && (!old_v || ready)) begin
                    m_valid = 1; m_rd = !wd; m_data = wd ? h_d[2] : 16'h0;
                    m_ad = h_ad[2]; m_sel = ~h_cs[2];
                end else if (old_v && ready) m_valid = 0;
                if (iss && old_v && !ready) m_ovf = 1;
            end
            if (m_state == 2 && rdv) m_hold = rdat;
            if (!aw) m_state = 0;
            else case (m_state)
                0: m_state = 1;
                1: if (rdn) m_state = 2;
                2: if (rdv) m_state = 3;
                3: if (rdn) m_state = 1;
                default: m_state = 0;
            endcase
            h_aw[2] = h_aw[1]; h_cs[2] = h_cs[1]; h_a[2] = h_a[1]; h_b[2] = h_b[1];
            h_ad[2] = h_ad[1]; h_d[2] = h_d[1];
            h_aw[1] = h_aw[0]; h_cs[1] = h_cs[0]; h_a[1] = h_a[0]; h_b[1] = h_b[0];
            h_ad[1] = h_ad[0]; h_d[1] = h_d[0];
            h_aw[0] = awake; h_cs[0] = csn; h_a[0] = sa; h_b[0] = sb; h_ad[0] = ad; h_d[0] = din;
        end
    end

    // Per-clock comparison, away from the edge
    always @(posedge clk) begin
        #2;
        if (rst_n && !done) begin
            logic exp_oe;
            chk("R11 txn_valid", t_valid, m_valid);
            if (m_valid) begin
                chk("R6 txn_data", t_data, m_data);
                chk("R6 txn_ad", t_ad, m_ad);
                chk("R7 txn_rd", t_rd, m_rd);
                chk("R5 txn_sel", t_sel, m_sel);
            end
            chk("R11 txn_ovf", t_ovf, m_ovf);
            chk("R8 irq", irq, m_state == 3);
            exp_oe = (m_state == 3) && (~&csn) && (mode ? ~sa : (sa & sb));
            chk("R9 bus_doe", doe, exp_oe);
            if (exp_oe) chk("R9 bus_dout", dout, m_hold);
        end
    end

    // Accepted-transaction log and watchdog
    always @(posedge clk) begin
        cyc++;
        if (rst_n && t_valid && ready) begin
            n_acc++; l_data = t_data; l_ad = t_ad; l_rd = t_rd; l_sel = t_sel;
        end
        if (cyc == 60000 && !done) begin
            failures++;
            $display("FAIL watchdog R1 actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr80(input logic [1:0] c, input logic a_d, input logic [15:0] dat, input bit cs_first);
        @(negedge clk); csn = c; ad = a_d; din = dat;
        idle(2); sb = 0; idle(4);
        if (cs_first) begin csn = 2'b11; idle(2); sb = 1; end
        else begin sb = 1; idle(2); csn = 2'b11; end
        idle(6);
    endtask

    task automatic rd80(input logic [1:0] c);
        @(negedge clk); csn = c;
        idle(2); sa = 0; idle(4); sa = 1; idle(1); csn = 2'b11; idle(6);
    endtask

    task automatic wr68(input logic [1:0] c, input logic a_d, input logic [15:0] dat, input bit e_static);
        @(negedge clk); ad = a_d; din = dat; sb = 0;
        if (e_static) begin
            sa = 1; idle(2); csn = c; idle(4); csn = 2'b11; idle(2); sa = 0; sb = 1;
        end else begin
            csn = c; idle(2); sa = 1; idle(4); sa = 0; idle(2); csn = 2'b11; sb = 1;
        end
        idle(6);
    endtask

    task automatic rd68(input logic [1:0] c);
        @(negedge clk); sb = 1; csn = c;
        idle(2); sa = 1; idle(4); sa = 0; idle(2); csn = 2'b11; idle(6);
    endtask

    task automatic ret_word(input logic [15:0] w);
        @(negedge clk); rdat = w; rdv = 1;
        @(negedge clk); rdv = 0;
        idle(2);
    endtask

    initial begin
        int base;
        idle(3);
        chk("R11 reset txn_valid", t_valid, 0);
        chk("R11 reset txn_ovf", t_ovf, 0);
        chk("R8 reset irq", irq, 0);
        chk("R9 reset bus_doe", doe, 0);
        rst_n = 1; awake = 1;
        idle(6);

        // R1/R6: 8080 write, write strobe released first, primary select, data
        wr80(2'b10, 1'b1, 16'h1234, 0);
        chk("R1 count", n_acc, 1);
        chk("R1 data", l_data, 16'h1234);
        chk("R6 ad=data", l_ad, 1);
        chk("R1 rd flag", l_rd, 0);
        chk("R5 sel primary", l_sel, 2'b01);

        // R2: chip select released first, secondary select, command
        wr80(2'b01, 1'b0, 16'h00A5, 1);
        chk("R2 count", n_acc, 2);
        chk("R2 data", l_data, 16'h00A5);
        chk("R6 ad=cmd", l_ad, 0);
        chk("R5 sel secondary", l_sel, 2'b10);

        // R5: strobes with no chip select are ignored
        @(negedge clk); din = 16'hFFFF; sb = 0; idle(4); sb = 1; sa = 0; idle(4); sa = 1; idle(6);
        chk("R5 ignored no select", n_acc, 2);
        chk("R5 ignored irq", irq, 0);

        // R7: first read issues request
        rd80(2'b10);
        chk("R7 count", n_acc, 3);
        chk("R7 rd flag", l_rd, 1);
        chk("R7 zero data", l_data, 0);
        chk("R7 irq low", irq, 0);

        // R8: returned word raises irq
        ret_word(16'hBEEF);
        chk("R8 irq set", irq, 1);

        // R9: no drive with read strobe but no select; drive during second read
        @(negedge clk); sa = 0; idle(3);
        chk("R9 no select no drive", doe, 0);
        sa = 1; idle(3);
        csn = 2'b10; idle(2); sa = 0; idle(2);
        chk("R9 drive enabled", doe, 1);
        chk("R9 drive value", dout, 16'hBEEF);
        sa = 1; idle(1);
        chk("R9 released", doe, 0);
        csn = 2'b11; idle(6);
        chk("R8 irq cleared", irq, 0);
        chk("R8 no txn on second read", n_acc, 3);

        // Switch to 6800 style while idle
        @(negedge clk); sa = 0; sb = 1; mode = 0; idle(4);

        // R3: enable falling edge capture
        wr68(2'b01, 1'b1, 16'h5A5A, 0);
        chk("R3 count", n_acc, 4);
        chk("R3 data", l_data, 16'h5A5A);
        chk("R3 write flag", l_rd, 0);
        chk("R5 sel secondary 68", l_sel, 2'b10);

        // R4: enable static high, chip select rising edge capture
        wr68(2'b10, 1'b0, 16'h0F0F, 1);
        chk("R4 count", n_acc, 5);
        chk("R4 data", l_data, 16'h0F0F);
        chk("R4 ad", l_ad, 0);

        // R3: 6800 read request
        rd68(2'b10);
        chk("R3 read count", n_acc, 6);
        chk("R3 read flag", l_rd, 1);

        // R10: power-down clears irq and blocks issue
        ret_word(16'hC0DE);
        chk("R8 irq set 68", irq, 1);
        @(negedge clk); awake = 0; idle(5);
        chk("R10 irq cleared", irq, 0);
        wr68(2'b10, 1'b1, 16'h7777, 0);
        chk("R10 no txn asleep", n_acc, 6);
        chk("R10 no valid asleep", t_valid, 0);
        @(negedge clk); awake = 1; idle(5);

        // R11: backpressure and overflow
        base = n_acc;
        @(negedge clk); ready = 0;
        wr68(2'b10, 1'b1, 16'h1111, 0);
        chk("R11 held valid", t_valid, 1);
        chk("R11 held data", t_data, 16'h1111);
        chk("R11 no ovf yet", t_ovf, 0);
        wr68(2'b10, 1'b1, 16'h2222, 0);
        chk("R11 ovf set", t_ovf, 1);
        chk("R11 first kept", t_data, 16'h1111);
        @(negedge clk); ready = 1; idle(3);
        chk("R11 accepted once", n_acc, base + 1);
        chk("R11 accepted data", l_data, 16'h1111);
        chk("R11 ovf sticky", t_ovf, 1);

        idle(4);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule